// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block services a circular ring of transmit descriptors that a host keeps in shared memory. The ring's position comes from two 16-bit words: the low half of the ring base address, and a packed length word. The length word carries the high byte of the base address and, in its top three bits, the base-2 logarithm of the number of entries. Each descriptor occupies four 16-bit words, so consecutive descriptors are eight bytes apart.

A transmit-demand pulse or a poll tick makes the engine read the flag word of the current descriptor. If the host has passed the descriptor to the controller, the engine does the following in order:
- fetches the buffer address and the negatively encoded byte count;
- asks a simple MAC for one frame and waits for its completion status;
- writes the status word back;
- writes the flag byte back with ownership returned to the host and retry/error marks set;
- raises a one-cycle transmit-interrupt event.

It then moves on to the next descriptor. It stops at the first descriptor that still belongs to the host.

A stop request abandons whatever descriptor is in progress and returns the ring index to entry 0. Memory accesses use a request/acknowledge word port with byte addresses.

Top module: `txr_engine`

## Requirements
- R1: During and after reset `memReq`, `macReq` and `tintEvt` are low, and the ring index is 0.
- R2: Word k (0..3) of descriptor i is at byte address B + 8*i + 2*k, where B = {ringLenWord[7:0], ringAddrLo}. The ring has 2^ringLenWord[15:13] entries, and the index wraps modulo that count. A 1-entry ring keeps reusing entry 0.
- R3: A `txDemand` pulse or a `pollTick` pulse while idle starts a check by reading word 1 of the current descriptor. In word 1 the flag byte sits in bits 15:8 with the ownership bit at bit 15 (1 = controller owns it), and the high buffer-address byte sits in bits 7:0.
- R4: If the flag read shows ownership 0, the engine makes no MAC request, writes nothing, raises no event and keeps its index. A later pulse re-reads the same descriptor.
- R5: Consider an owned descriptor whose flag has both start-of-packet (bit 1) and end-of-packet (bit 0) set. The engine reads word 0 and word 2, then holds `macReq` until `macDone`. It presents `macAddr` = {word1[7:0], word0} and `macLen` = the 12-bit two's-complement negation of word2[11:0].
- R6: On completion the engine writes `macStatus` into word 3. It writes word 1 as {flag, unchanged address byte}, where the flag byte is built as follows:
  - bit 7 (ownership) is 0;
  - bit 6 = `macFail`;
  - bit 5 is 0;
  - bit 4 = (`macRetries` >= 2 and not `macFail`);
  - bit 3 = (`macRetries` == 1 and not `macFail`);
  - bit 2 = `macDefer`;
  - bits 1:0 are kept from the descriptor.
- R7: `tintEvt` is a single-cycle pulse in the cycle after the word-1 write is acknowledged.
- R8: After finishing a descriptor the engine advances the index and checks the next one without a new pulse. It stops at the first descriptor not owned by the controller, so N armed descriptors give exactly N MAC requests.
- R9: Consider an owned descriptor lacking start-of-packet or end-of-packet. It gets no MAC request, word 3 is written with 16'h8000, and its flag byte gets bit 6 set and bit 7 cleared, with bits 1:0 kept and the other bits 0. `tintEvt` still pulses.
- R10: `stopReq` aborts the current descriptor: no further memory or MAC request, no write-back and no event, and the index returns to 0. A stop in the same cycle as a start pulse wins.
- R11: While `memReq` is high and unacknowledged, `memAddr`, `memWe` and `memWdata` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ringAddrLo | input | 16 | Low 16 bits of the ring base address |
| ringLenWord | input | 16 | Bits 15:13 log2 entry count, bits 7:0 base address high byte |
| txDemand | input | 1 | Transmit-demand pulse |
| pollTick | input | 1 | Periodic poll pulse |
| stopReq | input | 1 | Abort and reset the ring index |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 24 | Byte address of the 16-bit word |
| memWdata | output | 16 | Write data |
| memAck | input | 1 | Access accepted; read data valid |
| memRdata | input | 16 | Read data |
| macReq | output | 1 | Frame send request to the MAC |
| macAddr | output | 24 | Frame buffer address |
| macLen | output | 12 | Frame byte count |
| macDone | input | 1 | MAC completion pulse |
| macFail | input | 1 | Transmission failed |
| macRetries | input | 2 | Retry count (saturating) |
| macDefer | input | 1 | Transmission was deferred |
| macStatus | input | 16 | Status word to write back |
| tintEvt | output | 1 | One-cycle transmit-interrupt event |

## Verification
A stop request can land in the same cycle as a start pulse, or while a MAC transfer is still outstanding.

The bench provokes the first case by driving `stopReq` and `txDemand` together while an owned descriptor waits at index 0. It judges the result by the absence of any memory request in the following cycles, and by a later demand servicing that same entry 0.

For the second case it holds the MAC completion back, pulses stop, and then confirms three things: the descriptor is still controller-owned in memory, no write or event appeared, and the ring restarts at entry 0.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int WORD_W = 16;
  localparam int HI_W   = 8;
  localparam int ADDR_W = WORD_W + HI_W;
  localparam int LOG_W  = 3;
  localparam int IDX_W  = (1 << LOG_W) - 1;
  localparam int LEN_W  = 12;

  // flag byte bit positions
  localparam int F_OWN  = 7;
  localparam int F_ERR  = 6;
  localparam int F_MORE = 4;
  localparam int F_ONE  = 3;
  localparam int F_DEF  = 2;
  localparam int F_STP  = 1;
  localparam int F_ENP  = 0;
  localparam logic [WORD_W-1:0] STAT_BUFF = 16'h8000;

  typedef enum logic [3:0] {
    S_IDLE, S_RDFLAG, S_DECIDE, S_RDLO, S_RDLEN,
    S_MACW, S_WRSTAT, S_WRFLAG, S_DONE
  } txState_t;

  typedef struct packed {
    logic       ldFlag;
    logic       ldLo;
    logic       ldLen;
    logic       ldMac;
    logic       ldFrameErr;
    logic       advance;
    logic       clrIdx;
    logic [1:0] wordSel;
  } txStb_t;
endpackage

// File: rtl/txr_datapath.sv
module txr_datapath
  import txr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] ringAddrLo,
  input  logic [WORD_W-1:0] ringLenWord,
  input  txStb_t            stb,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              macFail,
  input  logic [1:0]        macRetries,
  input  logic              macDefer,
  input  logic [WORD_W-1:0] macStatus,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [ADDR_W-1:0] macAddr,
  output logic [LEN_W-1:0]  macLen,
  output logic              ownBit,
  output logic              frameOk
);
  logic [IDX_W-1:0]  idx, idxMask;
  logic [IDX_W:0]    sizeVal;
  logic [LOG_W-1:0]  ringLog;
  logic [ADDR_W-1:0] ringBase;
  logic [7:0]        flagReg, newFlag;
  logic [HI_W-1:0]   addrHi;
  logic [WORD_W-1:0] addrLo, statReg;
  logic [LEN_W-1:0]  lenReg;
  logic              unusedLenBits;

  assign unusedLenBits = ^ringLenWord[WORD_W-LOG_W-1:HI_W];
  assign ringLog  = ringLenWord[WORD_W-1 -: LOG_W];
  assign sizeVal  = (IDX_W+1)'(1) << ringLog;
  assign idxMask  = IDX_W'(sizeVal - 1'b1);
  assign ringBase = {ringLenWord[HI_W-1:0], ringAddrLo};
  assign memAddr  = ringBase + ADDR_W'({idx & idxMask, 3'b000}) + ADDR_W'({stb.wordSel, 1'b0});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx <= '0; flagReg <= '0; newFlag <= '0; addrHi <= '0;
      addrLo <= '0; statReg <= '0; lenReg <= '0;
    end else begin
      if (stb.clrIdx)       idx <= '0;
      else if (stb.advance) idx <= (idx + 1'b1) & idxMask;
      if (stb.ldFlag) begin
        flagReg <= memRdata[WORD_W-1:HI_W];
        addrHi  <= memRdata[HI_W-1:0];
      end
      if (stb.ldLo)  addrLo <= memRdata;
      if (stb.ldLen) lenReg <= memRdata[LEN_W-1:0];
      if (stb.ldMac) begin
        statReg <= macStatus;
        newFlag <= '0;
        newFlag[F_ERR]  <= macFail;
        newFlag[F_MORE] <= !macFail && (macRetries >= 2'd2);
        newFlag[F_ONE]  <= !macFail && (macRetries == 2'd1);
        newFlag[F_DEF]  <= macDefer;
        newFlag[F_STP]  <= flagReg[F_STP];
        newFlag[F_ENP]  <= flagReg[F_ENP];
      end else if (stb.ldFrameErr) begin
        statReg <= STAT_BUFF;
        newFlag <= '0;
        newFlag[F_ERR] <= 1'b1;
        newFlag[F_STP] <= flagReg[F_STP];
        newFlag[F_ENP] <= flagReg[F_ENP];
      end
    end
  end

  assign ownBit   = flagReg[F_OWN];
  assign frameOk  = flagReg[F_STP] && flagReg[F_ENP];
  assign macAddr  = {addrHi, addrLo};
  assign macLen   = LEN_W'(0) - lenReg;
  assign memWdata = (stb.wordSel == 2'd3) ? statReg : {newFlag, addrHi};
endmodule

// File: rtl/txr_ctrl.sv
module txr_ctrl
  import txr_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   txDemand,
  input  logic   pollTick,
  input  logic   stopReq,
  input  logic   memAck,
  input  logic   macDone,
  input  logic   ownBit,
  input  logic   frameOk,
  output txStb_t stb,
  output logic   memReq,
  output logic   memWe,
  output logic   macReq,
  output logic   tintEvt
);
  txState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stb = '0;
    stateNext = state;
    case (state)
      S_IDLE:   if (txDemand || pollTick) stateNext = S_RDFLAG;
      S_RDFLAG: begin
        stb.wordSel = 2'd1;
        if (memAck) begin stb.ldFlag = 1'b1; stateNext = S_DECIDE; end
      end
      S_DECIDE: begin
        if (!ownBit)      stateNext = S_IDLE;
        else if (frameOk) stateNext = S_RDLO;
        else begin stb.ldFrameErr = 1'b1; stateNext = S_WRSTAT; end
      end
      S_RDLO: begin
        stb.wordSel = 2'd0;
        if (memAck) begin stb.ldLo = 1'b1; stateNext = S_RDLEN; end
      end
      S_RDLEN: begin
        stb.wordSel = 2'd2;
        if (memAck) begin stb.ldLen = 1'b1; stateNext = S_MACW; end
      end
      S_MACW:   if (macDone) begin stb.ldMac = 1'b1; stateNext = S_WRSTAT; end
      S_WRSTAT: begin
        stb.wordSel = 2'd3;
        if (memAck) stateNext = S_WRFLAG;
      end
      S_WRFLAG: begin
        stb.wordSel = 2'd1;
        if (memAck) stateNext = S_DONE;
      end
      S_DONE: begin stb.advance = 1'b1; stateNext = S_RDFLAG; end
      default:  stateNext = S_IDLE;
    endcase
    if (stopReq) begin
      stateNext = S_IDLE;
      stb.clrIdx = 1'b1;
    end
  end

  assign memReq  = (state == S_RDFLAG) || (state == S_RDLO) || (state == S_RDLEN) ||
                   (state == S_WRSTAT) || (state == S_WRFLAG);
  assign memWe   = (state == S_WRSTAT) || (state == S_WRFLAG);
  assign macReq  = (state == S_MACW);
  assign tintEvt = (state == S_DONE);

  a_r7_tint_single: assert property (@(posedge clk) disable iff (!rstN)
    tintEvt |=> !tintEvt);
  a_r7_tint_after_write: assert property (@(posedge clk) disable iff (!rstN)
    tintEvt |-> $past(memReq && memWe && memAck));
  a_r10_stop_quiet: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> !memReq && !macReq && !tintEvt);
  a_r5_mac_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    macReq |-> !memReq);
endmodule

// File: rtl/txr_engine.sv
module txr_engine
  import txr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       ringAddrLo,
  input  logic [15:0]       ringLenWord,
  input  logic              txDemand,
  input  logic              pollTick,
  input  logic              stopReq,
  output logic              memReq,
  output logic              memWe,
  output logic [23:0]       memAddr,
  output logic [15:0]       memWdata,
  input  logic              memAck,
  input  logic [15:0]       memRdata,
  output logic              macReq,
  output logic [23:0]       macAddr,
  output logic [11:0]       macLen,
  input  logic              macDone,
  input  logic              macFail,
  input  logic [1:0]        macRetries,
  input  logic              macDefer,
  input  logic [15:0]       macStatus,
  output logic              tintEvt
);
  txStb_t stb;
  logic   ownBit, frameOk;

  txr_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .txDemand(txDemand), .pollTick(pollTick),
    .stopReq(stopReq), .memAck(memAck), .macDone(macDone),
    .ownBit(ownBit), .frameOk(frameOk), .stb(stb),
    .memReq(memReq), .memWe(memWe), .macReq(macReq), .tintEvt(tintEvt)
  );

  txr_datapath i_dp (
    .clk(clk), .rstN(rstN), .ringAddrLo(ringAddrLo), .ringLenWord(ringLenWord),
    .stb(stb), .memRdata(memRdata), .macFail(macFail), .macRetries(macRetries),
    .macDefer(macDefer), .macStatus(macStatus), .memAddr(memAddr),
    .memWdata(memWdata), .macAddr(macAddr), .macLen(macLen),
    .ownBit(ownBit), .frameOk(frameOk)
  );

  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck && !stopReq |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));
endmodule

// File: tb/test_txr_engine.sv
`timescale 1ns/1ps
module test_txr_engine;
  logic clk = 0, rstN = 0;
  logic [15:0] ringAddrLo = 16'h2340, ringLenWord = {3'd3, 5'd0, 8'h01};
  logic txDemand = 0, pollTick = 0, stopReq = 0;
  logic memReq, memWe, memAck, macReq, macDone, macFail, macDefer, tintEvt;
  logic [23:0] memAddr, macAddr;
  logic [15:0] memWdata, memRdata, macStatus;
  logic [11:0] macLen;
  logic [1:0]  macRetries;

  always #2 clk = ~clk;

  txr_engine i_txr_engine (.*);

  typedef struct { int idx; logic [23:0] addr; logic [11:0] len; logic [7:0] flag; } expReq_t;
  expReq_t expQ[$];
  bit [15:0] mem [int];
  logic [7:0]  expFlagArr [128];
  logic [15:0] expStatArr [128];
  logic [7:0]  armHi      [128];
  int nChecks = 0, nFails = 0, tintCount = 0, macCount = 0, memWrites = 0;
  int ringBase, ringMask, expIdx = 0;
  bit macHold = 0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int descAddr(int idx, int k);
    return ringBase + idx * 8 + k * 2;
  endfunction

  function automatic logic [7:0] expFlag(logic [7:0] orig, bit fail, logic [1:0] retr, bit dfr);
    return {1'b0, fail, 1'b0, !fail && retr >= 2, !fail && retr == 1, dfr, orig[1:0]};
  endfunction

  // memory model
  initial begin
    bit held = 0;
    int wt;
    logic [23:0] hA; logic hW; logic [15:0] hD;
    memAck = 0; memRdata = 0; wt = 0;
    forever begin
      @(negedge clk);
      if (memAck) begin
        memAck = 0; wt = $urandom % 3; held = 0;
      end else if (memReq) begin
        if (held) check(hA == memAddr && hW == memWe && hD == memWdata, "R11 request hold", memAddr, hA);
        held = 1; hA = memAddr; hW = memWe; hD = memWdata;
        if (wt == 0) begin
          memAck = 1;
          if (memWe) begin mem[int'(memAddr)] = memWdata; memWrites++; end
          else memRdata = mem.exists(int'(memAddr)) ? mem[int'(memAddr)] : 16'h0;
        end else wt--;
      end else held = 0;
    end
  end

  // MAC model
  initial begin
    bit seen = 0;
    int wt = 0, curIdx = 0;
    logic [7:0] curFlag = 0;
    expReq_t e;
    macDone = 0; macFail = 0; macRetries = 0; macDefer = 0; macStatus = 0;
    forever begin
      @(negedge clk);
      if (macDone) macDone = 0;
      else if (macReq) begin
        if (!seen) begin
          seen = 1; wt = $urandom % 4; macCount++;
          if (expQ.size() == 0) check(0, "R5 unexpected MAC request", macAddr, 0);
          else begin
            e = expQ.pop_front();
            check(macAddr == e.addr, "R5 MAC buffer address", macAddr, e.addr);
            check(macLen == e.len, "R5 MAC length", macLen, e.len);
            curIdx = e.idx; curFlag = e.flag;
          end
        end
        if (!macHold) begin
          if (wt == 0) begin
            macFail = ($urandom % 6) == 0;
            macRetries = 2'($urandom);
            macDefer = 1'($urandom);
            macStatus = 16'($urandom);
            macDone = 1; seen = 0;
            expFlagArr[curIdx] = expFlag(curFlag, macFail, macRetries, macDefer);
            expStatArr[curIdx] = macStatus;
          end else wt--;
        end
      end else seen = 0;
    end
  end

  // event monitor
  initial begin
    bit prev = 0;
    forever begin
      @(negedge clk);
      if (tintEvt) begin
        tintCount++;
        check(!prev, "R7 single-cycle event", 1, 0);
      end
      prev = tintEvt;
    end
  end

  task automatic arm(int idx, logic [7:0] flag);
    logic [23:0] a; int len;
    a = 24'($urandom) & 24'hFFFFFE;
    len = 60 + $urandom % 1455;
    mem[descAddr(idx, 0)] = a[15:0];
    mem[descAddr(idx, 1)] = {flag, a[23:16]};
    mem[descAddr(idx, 2)] = 16'hF000 | 16'(12'(-len));
    mem[descAddr(idx, 3)] = 16'h0;
    armHi[idx] = a[23:16];
    if (flag[7] && flag[1] && flag[0]) expQ.push_back('{idx, a, 12'(len), flag});
  endtask

  task automatic pulse(bit usePoll);
    @(negedge clk);
    if (usePoll) pollTick = 1; else txDemand = 1;
    @(negedge clk);
    pollTick = 0; txDemand = 0;
  endtask

  task automatic settle(); repeat (25) @(negedge clk); endtask

  task automatic waitTints(int target);
    int t = 0;
    while (tintCount < target && t < 3000) begin @(negedge clk); t++; end
    check(tintCount >= target, "R8 completion events", tintCount, target);
  endtask

  task automatic verify(int idx, string tag);
    logic [15:0] w1, w3;
    w1 = mem[descAddr(idx, 1)]; w3 = mem[descAddr(idx, 3)];
    check(w1[15:8] == expFlagArr[idx], {tag, " flag byte"}, w1[15:8], expFlagArr[idx]);
    check(w1[7:0] == armHi[idx], {tag, " address byte kept"}, w1[7:0], armHi[idx]);
    check(w3 == expStatArr[idx], {tag, " status word"}, w3, expStatArr[idx]);
  endtask

  task automatic setRing(logic [15:0] lo, logic [2:0] lg, logic [7:0] hi);
    @(negedge clk); stopReq = 1; @(negedge clk); stopReq = 0;
    ringAddrLo = lo; ringLenWord = {lg, 5'd0, hi};
    ringBase = {hi, lo}; ringMask = (1 << lg) - 1; expIdx = 0;
    for (int i = 0; i <= ringMask; i++) mem[descAddr(i, 1)] = 16'h0;
  endtask

  task automatic randomRounds(int rounds);
    int n, tc, mc;
    for (int r = 0; r < rounds; r++) begin
      n = 1 + ($urandom % (ringMask + 1));
      tc = tintCount; mc = macCount;
      for (int j = 0; j < n; j++) arm((expIdx + j) & ringMask, 8'h83);
      pulse(r % 2);
      waitTints(tc + n);
      settle();
      for (int j = 0; j < n; j++) verify((expIdx + j) & ringMask, "R6");
      check(macCount == mc + n, "R8 chain stops at host-owned entry", macCount, mc + n);
      check(tintCount == tc + n, "R7 one event per descriptor", tintCount, tc + n);
      expIdx = (expIdx + n) & ringMask;
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int tc, mc, wc, t;
    logic [15:0] w;
    void'($urandom(32'd20240611));
    ringBase = 24'h012340; ringMask = 7;
    for (int i = 0; i < 8; i++) mem[descAddr(i, 1)] = 16'h0;
    repeat (3) @(negedge clk);
    check(!memReq && !macReq && !tintEvt, "R1 outputs in reset", {memReq, macReq, tintEvt}, 0);
    rstN = 1;
    repeat (3) @(negedge clk);
    check(!memReq && !macReq && !tintEvt, "R1 outputs after reset", {memReq, macReq, tintEvt}, 0);

    // R3/R2/R4: demand with nothing owned
    pulse(0);
    t = 0;
    while (!memReq && t < 10) begin @(negedge clk); t++; end
    check(memReq && !memWe && memAddr == 24'(descAddr(0, 1)), "R2 R3 first flag read at index 0", memAddr, descAddr(0, 1));
    settle();
    check(macCount == 0 && memWrites == 0 && tintCount == 0, "R4 unowned entry untouched", {macCount[7:0], memWrites[7:0], tintCount[7:0]}, 0);

    // R4 recheck on poll after host hands over
    arm(0, 8'h83);
    tc = tintCount;
    pulse(1);
    waitTints(tc + 1);
    settle();
    verify(0, "R4 recheck");
    check(macCount == 1, "R3 poll starts service", macCount, 1);
    expIdx = 1;

    randomRounds(6);

    // R9 framing error
    tc = tintCount; mc = macCount;
    arm(expIdx, 8'h82);
    expFlagArr[expIdx] = 8'h42; expStatArr[expIdx] = 16'h8000;
    pulse(0);
    waitTints(tc + 1);
    settle();
    verify(expIdx, "R9");
    check(macCount == mc, "R9 no MAC request", macCount, mc);
    expIdx = (expIdx + 1) & ringMask;

    // R10 stop during MAC transfer
    macHold = 1;
    tc = tintCount; wc = memWrites;
    arm(expIdx, 8'h83);
    pulse(0);
    t = 0;
    while (!macReq && t < 50) begin @(negedge clk); t++; end
    check(macReq, "R10 MAC request reached", macReq, 1);
    stopReq = 1; @(negedge clk); stopReq = 0;
    check(!memReq && !macReq, "R10 requests dropped", {memReq, macReq}, 0);
    settle();
    w = mem[descAddr(expIdx, 1)];
    check(w[15:8] == 8'h83, "R10 no write-back of aborted entry", w[15:8], 8'h83);
    check(memWrites == wc && tintCount == tc, "R10 no writes or event", memWrites, wc);
    macHold = 0;
    mem[descAddr(expIdx, 1)] = 16'h0;
    expIdx = 0;

    // R10 stop and demand in one cycle
    arm(0, 8'h83);
    @(negedge clk); stopReq = 1; txDemand = 1;
    @(negedge clk); stopReq = 0; txDemand = 0;
    for (int i = 0; i < 6; i++) begin
      check(!memReq, "R10 stop beats demand", memReq, 0);
      @(negedge clk);
    end
    tc = tintCount;
    pulse(0);
    waitTints(tc + 1);
    settle();
    verify(0, "R10 restart at index 0");

    // R2 one-entry ring
    setRing(16'h8000, 3'd0, 8'h05);
    for (int k = 0; k < 2; k++) begin
      tc = tintCount; mc = macCount;
      arm(0, 8'h83);
      pulse(k);
      waitTints(tc + 1);
      settle();
      verify(0, "R2 single entry ring");
      check(macCount == mc + 1, "R2 single entry wraps to itself", macCount, mc + 1);
    end

    // R2 four-entry ring wrapping
    setRing(16'h1000, 3'd2, 8'h3A);
    randomRounds(4);

    finishRun();
  end
endmodule